// File: doc/BRIEF.md
# Interrupt Status and Vector Logic

This block keeps the event status of a serial bus master peripheral together with its interrupt enable mask and its DMA request configuration. The transfer logic raises single-cycle set pulses (and hardware clear pulses) for events such as receive-ready, transmit-ready, access-ready, no-acknowledge, underflow, overrun and single-byte data. From these the block derives one combined interrupt line and two DMA request lines, one for receive and one for transmit. All three are registered.

Software reaches the block through a simple register port. A select code picks the register, a write strobe chooses write or read, and read data is returned in the same cycle as the access. Any side effect of an access takes place at the clock edge that ends the access cycle. The parameter `REVISION` picks the acknowledge scheme:

- **Legacy** (`REVISION < 0x34`): a read of the vector register returns the lowest pending enabled event and clears it.
- **Current** (`REVISION >= 0x34`): software clears events by writing ones to the status register, a test write can force the low six events, and the enable mask gains a sixth bit.

The access "modes" are the register selects: mask, status, vector, buffer config and test. Unused codes read as zero.

Top module: `irq_status_vector`

## Requirements
- R1: After reset, status, enable mask and buffer config read as zero, and the interrupt and both DMA request outputs are low.
- R2: `irq` equals the OR of (status AND enable mask), registered, so it reflects the state one clock after any change of status or mask.
- R3: A set pulse on `evt_set[i]` sets status bit i. A pulse on `evt_clr[i]` clears it. A set wins over any clear of the same bit in the same cycle, whether that clear comes from hardware, a status write or a vector read.
- R4: Select codes are 0 mask, 1 status, 2 vector, 3 buffer config, 4 test; codes 5 to 7 read zero and ignore writes. A mask write keeps bits 4:0 on the legacy revision and bits 5:0 on the current revision (threshold 0x34).
- R5: A buffer-config write stores only bit 15 (receive DMA enable) and bit 7 (transmit DMA enable). Writing bit 15 as one clears mask bit 3, and writing bit 7 as one clears mask bit 4.
- R6: `rx_dma_req` is the registered value of receive-ready (status bit 3) while the receive DMA enable is set, and low otherwise. `tx_dma_req` does the same with transmit-ready (status bit 4) and the transmit DMA enable.
- R7: On the legacy revision, a vector read returns one plus the index of the lowest set bit of (status AND mask), or zero when none is set, and clears that status bit.
- R8: On the current revision, a vector read returns zero and changes nothing.
- R9: On the current revision, a status write clears the status bits set in (written value AND 0x0027), so receive-ready and transmit-ready stay unchanged. On the legacy revision a status write is ignored.
- R10: On the current revision, a test write with bit 11 set forces status bits 5:0 to one. On the legacy revision it has no effect.
- R11: A status read returns the stored status with bit 12 replaced by the live `bus_busy` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Register access valid this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 3 | Register select code |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data, combinational from current state |
| evt_set | input | 16 | Per-bit event set pulses from transfer logic |
| evt_clr | input | 16 | Per-bit hardware clear pulses from transfer logic |
| bus_busy | input | 1 | Live bus-busy flag shown in status reads |
| irq | output | 1 | Combined interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The bench drives one legacy and one current instance with the same stimulus and tracks both against a behavioural model on every clock.

It aims at these corners:

- **Vector read with an event enabled only on the current revision.** A design that ignored the narrower legacy mask would return a vector for bit 5.
- **Repeated vector reads.** A wrong priority would return the events out of order or clear the wrong one.
- **Status write of all ones.** A design that let software clear the ready bits would drop the DMA requests.
- **A set and a clear of the same bit in the same cycle.** A design that gave the clear priority would lose the event.
- **Buffer-config writes.** These must strip mask bits 3 and 4 and ignore the other bits.
- **Test-force write on the legacy instance.** This must leave its status unchanged.

// File: rtl/isv_pkg.sv
package isv_pkg;

    typedef enum logic [2:0] {
        SEL_MASK   = 3'd0,
        SEL_STATUS = 3'd1,
        SEL_VECTOR = 3'd2,
        SEL_BUFCFG = 3'd3,
        SEL_TEST   = 3'd4
    } reg_sel_e;

    localparam int unsigned BIT_RRDY     = 3;
    localparam int unsigned BIT_XRDY     = 4;
    localparam int unsigned BIT_BUSY     = 12;
    localparam int unsigned CFG_RX_BIT   = 15;
    localparam int unsigned CFG_TX_BIT   = 7;
    localparam int unsigned FORCE_BIT    = 11;
    localparam logic [7:0]  NEW_REV_MIN  = 8'h34;
    localparam logic [15:0] SW_CLR_MASK  = 16'h0027;
    localparam logic [15:0] FORCE_VALUE  = 16'h003f;

endpackage

// File: rtl/isv_status_reg.sv
module isv_status_reg #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_i,
    input  logic [DATA_W-1:0] clr_i,
    output logic [DATA_W-1:0] status_o
);

    // Set has priority: a bit that is both set and cleared ends up set.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_o <= '0;
        end else begin
            status_o <= (status_o & ~clr_i) | set_i;
        end
    end

    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((status_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/isv_mask_cfg.sv
module isv_mask_cfg #(
    parameter int unsigned MASK_W = 6,
    parameter bit          NEWER  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_wr_i,
    input  logic              cfg_wr_i,
    input  logic [MASK_W-1:0] mask_data_i,
    input  logic              cfg_rx_i,
    input  logic              cfg_tx_i,
    output logic [MASK_W-1:0] mask_o,
    output logic              rx_en_o,
    output logic              tx_en_o
);
    import isv_pkg::*;

    localparam int unsigned        KEEP_W    = NEWER ? MASK_W : MASK_W - 1;
    localparam logic [MASK_W-1:0] KEEP_MASK = MASK_W'((1 << KEEP_W) - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o  <= '0;
            rx_en_o <= 1'b0;
            tx_en_o <= 1'b0;
        end else if (mask_wr_i) begin
            mask_o <= mask_data_i & KEEP_MASK;
        end else if (cfg_wr_i) begin
            rx_en_o <= cfg_rx_i;
            tx_en_o <= cfg_tx_i;
            if (cfg_rx_i) mask_o[BIT_RRDY] <= 1'b0;
            if (cfg_tx_i) mask_o[BIT_XRDY] <= 1'b0;
        end
    end

    assert_rx_strip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && cfg_rx_i) |=> !mask_o[BIT_RRDY]);

    assert_tx_strip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && cfg_tx_i) |=> !mask_o[BIT_XRDY]);

    generate
        if (!NEWER) begin : g_legacy_width
            assert_mask_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
                mask_wr_i |=> !mask_o[MASK_W-1]);
        end
    endgenerate

endmodule

// File: rtl/isv_vector_enc.sv
module isv_vector_enc #(
    parameter int unsigned N = 6,
    parameter int unsigned W = 3
) (
    input  logic [N-1:0] pend_i,
    output logic [W-1:0] code_o,
    output logic [N-1:0] first_o
);

    // Scan from the top so the lowest pending index is the last assignment.
    always_comb begin
        code_o  = '0;
        first_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                code_o     = W'(i + 1);
                first_o    = '0;
                first_o[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_status_vector.sv
module irq_status_vector #(
    parameter logic [7:0]  REVISION = 8'h34,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned MASK_W   = 6,
    parameter int unsigned SEL_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [SEL_W-1:0]  acc_sel,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic [DATA_W-1:0] evt_set,
    input  logic [DATA_W-1:0] evt_clr,
    input  logic              bus_busy,
    output logic              irq,
    output logic              rx_dma_req,
    output logic              tx_dma_req
);
    import isv_pkg::*;

    localparam bit          NEWER = (REVISION >= NEW_REV_MIN);
    localparam int unsigned VEC_W = $clog2(MASK_W + 1);

    reg_sel_e           sel;
    logic               rd_hit;
    logic               wr_hit;
    logic [DATA_W-1:0]  status;
    logic [MASK_W-1:0]  mask;
    logic               rx_en;
    logic               tx_en;
    logic [MASK_W-1:0]  pend;
    logic [VEC_W-1:0]   vec_code;
    logic [MASK_W-1:0]  vec_first;
    logic [DATA_W-1:0]  sw_clr;
    logic [DATA_W-1:0]  vec_clr;
    logic [DATA_W-1:0]  force_set;
    logic [DATA_W-1:0]  set_all;
    logic [DATA_W-1:0]  clr_all;

    assign sel    = reg_sel_e'(acc_sel);
    assign wr_hit = acc_en && acc_we;
    assign rd_hit = acc_en && !acc_we;
    assign pend   = status[MASK_W-1:0] & mask;

    isv_vector_enc #(.N(MASK_W), .W(VEC_W)) u_vec (
        .pend_i  (pend),
        .code_o  (vec_code),
        .first_o (vec_first)
    );

    // Revision-dependent clear and force sources.
    generate
        if (NEWER) begin : g_current
            assign sw_clr    = (wr_hit && sel == SEL_STATUS) ? (acc_wdata & SW_CLR_MASK) : '0;
            assign force_set = (wr_hit && sel == SEL_TEST && acc_wdata[FORCE_BIT]) ? FORCE_VALUE : '0;
            assign vec_clr   = '0;
        end else begin : g_legacy
            assign sw_clr    = '0;
            assign force_set = '0;
            assign vec_clr   = (rd_hit && sel == SEL_VECTOR)
                               ? {{(DATA_W-MASK_W){1'b0}}, vec_first} : '0;
        end
    endgenerate

    assign set_all = evt_set | force_set;
    assign clr_all = evt_clr | sw_clr | vec_clr;

    isv_status_reg #(.DATA_W(DATA_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_all),
        .clr_i    (clr_all),
        .status_o (status)
    );

    isv_mask_cfg #(.MASK_W(MASK_W), .NEWER(NEWER)) u_mask (
        .clk         (clk),
        .rst_n       (rst_n),
        .mask_wr_i   (wr_hit && sel == SEL_MASK),
        .cfg_wr_i    (wr_hit && sel == SEL_BUFCFG),
        .mask_data_i (acc_wdata[MASK_W-1:0]),
        .cfg_rx_i    (acc_wdata[CFG_RX_BIT]),
        .cfg_tx_i    (acc_wdata[CFG_TX_BIT]),
        .mask_o      (mask),
        .rx_en_o     (rx_en),
        .tx_en_o     (tx_en)
    );

    // Read multiplexer.
    always_comb begin
        acc_rdata = '0;
        unique case (sel)
            SEL_MASK:   acc_rdata = {{(DATA_W-MASK_W){1'b0}}, mask};
            SEL_STATUS: begin
                acc_rdata           = status;
                acc_rdata[BIT_BUSY] = bus_busy;
            end
            SEL_VECTOR: acc_rdata = NEWER ? '0 : {{(DATA_W-VEC_W){1'b0}}, vec_code};
            SEL_BUFCFG: begin
                acc_rdata[CFG_RX_BIT] = rx_en;
                acc_rdata[CFG_TX_BIT] = tx_en;
            end
            default:    acc_rdata = '0;
        endcase
    end

    // Registered request outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq        <= 1'b0;
            rx_dma_req <= 1'b0;
            tx_dma_req <= 1'b0;
        end else begin
            irq        <= |pend;
            rx_dma_req <= rx_en && status[BIT_RRDY];
            tx_dma_req <= tx_en && status[BIT_XRDY];
        end
    end

    assert_rx_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_dma_req);

    assert_tx_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !tx_dma_req);

    assert_vec_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|vec_clr) && !(|(vec_clr & set_all))) |=> !(|(status & $past(vec_clr))));

    assert_ready_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && sel == SEL_STATUS && !(|evt_clr[BIT_XRDY:BIT_RRDY]))
        |=> ((status[BIT_XRDY:BIT_RRDY] & $past(status[BIT_XRDY:BIT_RRDY]))
             == $past(status[BIT_XRDY:BIT_RRDY])));

endmodule

// File: tb/irq_status_vector_tb.sv
module irq_status_vector_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_we = 1'b0;
    logic [2:0]  acc_sel = 3'd0;
    logic [15:0] acc_wdata = 16'h0;
    logic [15:0] evt_set = 16'h0;
    logic [15:0] evt_clr = 16'h0;
    logic        bus_busy = 1'b0;
    logic [15:0] rdata [2];
    logic        irq_o [2];
    logic        rxd_o [2];
    logic        txd_o [2];

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    irq_status_vector #(.REVISION(8'h20)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
        .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_rdata(rdata[0]),
        .evt_set(evt_set), .evt_clr(evt_clr), .bus_busy(bus_busy),
        .irq(irq_o[0]), .rx_dma_req(rxd_o[0]), .tx_dma_req(txd_o[0]));

    irq_status_vector #(.REVISION(8'h40)) u_dut_new (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
        .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_rdata(rdata[1]),
        .evt_set(evt_set), .evt_clr(evt_clr), .bus_busy(bus_busy),
        .irq(irq_o[1]), .rx_dma_req(rxd_o[1]), .tx_dma_req(txd_o[1]));

    // Behavioural model, index 0 = legacy, 1 = current.
    logic [15:0] m_st [2];
    logic [5:0]  m_mk [2];
    logic        m_rx [2];
    logic        m_tx [2];
    logic        e_irq [2];
    logic        e_rxd [2];
    logic        e_txd [2];

    function automatic int lowest_vec(input logic [15:0] st, input logic [5:0] mk);
        for (int i = 0; i < 6; i++) if (st[i] && mk[i]) return i + 1;
        return 0;
    endfunction

    function automatic logic [15:0] model_rd(input int k);
        logic [15:0] r;
        case (acc_sel)
            3'd0: r = {10'h0, m_mk[k]};
            3'd1: begin r = m_st[k]; r[12] = bus_busy; end
            3'd2: r = (k == 0) ? 16'(lowest_vec(m_st[k], m_mk[k])) : 16'h0;
            3'd3: r = {m_rx[k], 7'h0, m_tx[k], 7'h0};
            default: r = 16'h0;
        endcase
        return r;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string rd_tag(input int k);
        case (acc_sel)
            3'd0: return "R4 mask";
            3'd1: return "R3,R9,R10,R11 status";
            3'd2: return (k == 0) ? "R7 vector" : "R8 vector";
            3'd3: return "R5 bufcfg";
            default: return "R4 unused select";
        endcase
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                m_st[k] = '0; m_mk[k] = '0; m_rx[k] = 0; m_tx[k] = 0;
                e_irq[k] = 0; e_rxd[k] = 0; e_txd[k] = 0;
            end
        end else begin
            for (int k = 0; k < 2; k++) begin
                logic [15:0] setv, clrv;
                int v;
                check("R2 irq", {15'h0, irq_o[k]}, {15'h0, e_irq[k]});
                check("R6 rx dma", {15'h0, rxd_o[k]}, {15'h0, e_rxd[k]});
                check("R6 tx dma", {15'h0, txd_o[k]}, {15'h0, e_txd[k]});
                if (acc_en && !acc_we) check(rd_tag(k), rdata[k], model_rd(k));
                // advance the model to the coming edge
                e_irq[k] = |(m_st[k][5:0] & m_mk[k]);
                e_rxd[k] = m_rx[k] & m_st[k][3];
                e_txd[k] = m_tx[k] & m_st[k][4];
                setv = evt_set;
                clrv = evt_clr;
                if (k == 1 && acc_en && acc_we && acc_sel == 3'd4 && acc_wdata[11]) setv |= 16'h003f;
                if (k == 1 && acc_en && acc_we && acc_sel == 3'd1) clrv |= acc_wdata & 16'h0027;
                v = lowest_vec(m_st[k], m_mk[k]);
                if (k == 0 && acc_en && !acc_we && acc_sel == 3'd2 && v != 0) clrv[v-1] = 1'b1;
                m_st[k] = (m_st[k] & ~clrv) | setv;
                if (acc_en && acc_we && acc_sel == 3'd0)
                    m_mk[k] = acc_wdata[5:0] & ((k == 1) ? 6'h3f : 6'h1f);
                if (acc_en && acc_we && acc_sel == 3'd3) begin
                    m_rx[k] = acc_wdata[15];
                    m_tx[k] = acc_wdata[7];
                    if (acc_wdata[15]) m_mk[k][3] = 1'b0;
                    if (acc_wdata[7])  m_mk[k][4] = 1'b0;
                end
            end
        end
    end

    task automatic cyc(input logic en, input logic we, input logic [2:0] sel,
                       input logic [15:0] wd, input logic [15:0] st, input logic [15:0] cl,
                       input logic busy);
        @(posedge clk); #1;
        acc_en = en; acc_we = we; acc_sel = sel; acc_wdata = wd;
        evt_set = st; evt_clr = cl; bus_busy = busy;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] wd);
        cyc(1, 1, sel, wd, 16'h0, 16'h0, 1'b0);
    endtask

    task automatic rd(input logic [2:0] sel, input logic busy);
        cyc(1, 0, sel, 16'h0, 16'h0, 16'h0, busy);
    endtask

    task automatic ev(input logic [15:0] st, input logic [15:0] cl);
        cyc(0, 0, 3'd0, 16'h0, st, cl, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 3'd0, 16'h0, 16'h0, 16'h0, 1'b0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(1);
        // R1: reset state via outputs and every register
        for (int s = 0; s < 8; s++) rd(3'(s), 1'b0);
        // R4: mask width per revision
        wr(3'd0, 16'hffff); rd(3'd0, 0);
        // R3 / R2: events and registered irq
        ev(16'h0006, 16'h0); idle(2);
        rd(3'd1, 1'b1); rd(3'd1, 1'b0);          // R11 live busy
        // R7 / R8: successive vector reads
        rd(3'd2, 0); rd(3'd2, 0); rd(3'd2, 0); idle(1);
        // bit 5 enabled only on current revision
        ev(16'h0020, 16'h0); idle(1);
        rd(3'd2, 0); rd(3'd1, 0); idle(2);
        // R9: status write of all ones spares ready bits
        ev(16'h8c18, 16'h0); idle(1);
        wr(3'd1, 16'hffff); rd(3'd1, 0); idle(1);
        // R3: set and software clear of the same bit in one cycle
        cyc(1, 1, 3'd1, 16'h0002, 16'h0002, 16'h0000, 0); rd(3'd1, 0);
        // R3: set and hardware clear together
        ev(16'h0100, 16'h0100); rd(3'd1, 0);
        // R5 / R6: DMA enables strip mask bits and gate requests
        wr(3'd0, 16'h003f); wr(3'd3, 16'hffff); rd(3'd3, 0); rd(3'd0, 0); idle(2);
        ev(16'h0, 16'h0008); idle(2);
        ev(16'h0, 16'h0010); idle(2);
        ev(16'h0018, 16'h0); idle(2);
        wr(3'd3, 16'h0080); idle(2); rd(3'd3, 0);
        // R10: forced low six bits
        ev(16'h0, 16'hffff); idle(1);
        wr(3'd4, 16'h0800); rd(3'd1, 0); idle(2);
        // R7: vector with mask cleared
        wr(3'd0, 16'h0000); rd(3'd2, 0); idle(1);
        wr(3'd0, 16'h0001); rd(3'd2, 0); rd(3'd2, 0); idle(1);
        // R4: unused selects ignore writes and read zero
        wr(3'd5, 16'hffff); wr(3'd7, 16'hffff);
        for (int s = 0; s < 8; s++) rd(3'(s), 1'b0);
        idle(3);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule